// File: doc/BRIEF.md
# I2C Slave Controller with Acknowledge Gating

This block is the byte-level engine of an I2C slave. It watches the open-drain SCL and SDA lines through a synchronizer, finds START and STOP conditions, shifts bytes in and out, and decides whether to acknowledge each byte. After every byte that needs software attention it posts an 8-bit status code, raises a service flag and holds SCL low until software clears the flag. The block answers to a 7-bit own address and, when allowed, to the general call address.

Two controls decide how far the slave takes part in bus traffic. The acknowledge-enable input (`ack_en_i`) detaches the slave from address recognition without losing track of the bus. While it is low, the slave still sees START and STOP conditions and still shifts data into its receive register, but it acknowledges nothing. The acknowledge decision is taken when a byte completes, so an address that was already partly received when the control is raised is still recognized. The block-enable input (`enable_i`) releases both line drivers and returns the engine to its idle, not-addressed state.

Software reads `rx_byte_o` and `status_o` when the flag is up. It writes the next byte to transmit on `tx_byte_i`, sets the acknowledge-enable input to say whether more bytes will follow, and pulses `flag_clr_i`.

Top module: `i2cs_gated_slave`

## Requirements
- R1: After reset, and whenever `enable_i` is low, `status_o` is 0xF8, `flag_o` is 0 and both output enables are 0. With `enable_i` low, traffic on the lines does not change these outputs. In particular, the own address is not acknowledged, because SDA is not pulled low in the ninth clock.
- R2: A byte whose upper seven bits match `own_addr_i` and whose bit 0 (R/W) is 0, received with `ack_en_i`=1, is acknowledged by pulling SDA low in the ninth clock. Status then becomes 0x60 and `flag_o` rises. The status code never changes while `enable_i` stays high without `flag_o` being 1.
- R3: Once the flag is raised at the end of an acknowledge clock, `scl_oe_o` is 1 and holds SCL low. The flag and the stretch stay up until `flag_clr_i` is pulsed, and the pulse drops both.
- R4: As an addressed receiver, a data byte received with `ack_en_i`=1 is acknowledged, gives status 0x80 and appears on `rx_byte_o`. With `ack_en_i`=0 the byte is not acknowledged (SDA stays high), the status becomes 0x88 and the slave is no longer addressed, so later bytes of that transfer are neither acknowledged nor flagged.
- R5: The address byte 0x00 is acknowledged only when both `gcall_en_i` and `ack_en_i` are 1, and it gives status 0x70. Following data bytes give 0x90 when acknowledged and 0x98 when not. With `gcall_en_i`=0 the byte 0x00 is ignored.
- R6: An own-address match with R/W=1 is acknowledged with status 0x A8. The byte on `tx_byte_i` at the flag clear is then sent MSB first. SDA changes only while SCL is low.
- R7: After a transmitted byte, a master acknowledge (SDA low in the ninth clock) gives status 0xB8 if `ack_en_i` was 1 at the flag clear. A master not-acknowledge gives status 0xC0 and ends the addressed state.
- R8: If `ack_en_i` was 0 at the flag clear that started a transmitted byte and the master acknowledges it, status becomes 0xC8. SDA is then released and the slave is not addressed, so later clocks read 0xFF with no flag.
- R9: While not addressed and with `ack_en_i`=0, neither the own address nor 0x00 is acknowledged, the flag stays low and the status is unchanged.
- R10: While detached, data bytes are still shifted into `rx_byte_o`, and START and STOP are still tracked. A new START after the control is raised leads to normal address recognition.
- R11: If `ack_en_i` rises while an own address byte is partly received, the address is recognized when the byte completes.
- R12: A STOP or a repeated START while the slave is an addressed receiver gives status 0xA0 with `flag_o`=1 and `scl_oe_o`=0.
- R13: An address byte that matches neither the own address nor an enabled general call is ignored: no acknowledge, no flag, no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; low releases both lines and idles the engine |
| ack_en_i | input | 1 | Acknowledge enable; low detaches from address recognition |
| gcall_en_i | input | 1 | Allow the general call address |
| own_addr_i | input | 7 | Own 7-bit slave address |
| flag_clr_i | input | 1 | One-cycle pulse that clears the service flag |
| tx_byte_i | input | 8 | Byte to send, captured at the flag clear in transmit mode |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| flag_o | output | 1 | Service flag |
| status_o | output | 8 | Status code |
| rx_byte_o | output | 8 | Receive shift register |

## Verification
The bench raises the acknowledge-enable input in the middle of an address byte. A design that latched its decision early would miss that address. It also sends the own address and a data byte while detached and then opens a new transfer. A slave that stopped tracking the bus would fail to shift the byte or would miss the later START. On the transmit side, the bench ends one byte with a master acknowledge and the enable low, and then reads once more. A wrong design would keep driving SDA or report 0xB8 instead of 0xC8. A STOP and a repeated START are each sent while the slave is addressed, which catches a missing 0xA0 or a stretch where none belongs. Traffic with the block disabled shows whether any input leaks through.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_SKIP, PH_RX, PH_GC, PH_TX
    } phase_e;

    localparam logic [7:0] ST_IDLE    = 8'hF8;
    localparam logic [7:0] ST_OWN_W   = 8'h60;
    localparam logic [7:0] ST_GC      = 8'h70;
    localparam logic [7:0] ST_RX_ACK  = 8'h80;
    localparam logic [7:0] ST_RX_NACK = 8'h88;
    localparam logic [7:0] ST_GC_ACK  = 8'h90;
    localparam logic [7:0] ST_GC_NACK = 8'h98;
    localparam logic [7:0] ST_STOP    = 8'hA0;
    localparam logic [7:0] ST_OWN_R   = 8'hA8;
    localparam logic [7:0] ST_TX_ACK  = 8'hB8;
    localparam logic [7:0] ST_TX_NACK = 8'hC0;
    localparam logic [7:0] ST_TX_LAST = 8'hC8;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                ack;
        phase_e              tgt;
        logic [BYTE_W-1:0]   tx_sh;
        logic                tx_act;
        logic                last;
        logic                mack;
        logic [7:0]          status;
        logic                irq;
        logic                stretch;
    } eng_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;
        logic              prev_d, prev_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw[g]};
            prev_d  = chain_q[STAGES-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign lvl[g]  = chain_q[STAGES-1];
        assign prev[g] = prev_q;
    end

    assign scl_o      = lvl[0];
    assign sda_o      = lvl[1];
    assign scl_rise_o = lvl[0] & ~prev[0];
    assign scl_fall_o = ~lvl[0] & prev[0];
    assign start_o    = lvl[0] & prev[0] & prev[1] & ~lvl[1];
    assign stop_o     = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
    import i2cs_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gcall_en_i,
    output logic              own_hit_o,
    output logic              gc_hit_o,
    output logic              read_o
);
    always_comb begin
        own_hit_o = (byte_i[BYTE_W-1:1] == own_addr_i);
        gc_hit_o  = gcall_en_i && (byte_i == '0) && !own_hit_o;
        read_o    = byte_i[0];
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              ack_en_i,
    input  logic              gcall_en_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              flag_clr_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              sda_oe_o,
    output logic              scl_oe_o,
    output logic              flag_o,
    output logic [7:0]        status_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(BYTE_W + 1);
    localparam eng_t ENG_RST = '{
        phase: PH_IDLE, cnt: '0, sh: '0, ack: 1'b0, tgt: PH_SKIP,
        tx_sh: '0, tx_act: 1'b0, last: 1'b0, mack: 1'b0,
        status: ST_IDLE, irq: 1'b0, stretch: 1'b0
    };

    eng_t eng_d, eng_q;
    logic own_hit, gc_hit, rd_bit;
    logic addressed;
    logic ev;
    logic [7:0] ev_code;

    i2cs_addr_match i_match (
        .byte_i     (eng_q.sh),
        .own_addr_i (own_addr_i),
        .gcall_en_i (gcall_en_i),
        .own_hit_o  (own_hit),
        .gc_hit_o   (gc_hit),
        .read_o     (rd_bit)
    );

    always_comb begin
        eng_d     = eng_q;
        ev        = 1'b0;
        ev_code   = ST_IDLE;
        addressed = (eng_q.phase == PH_RX) || (eng_q.phase == PH_GC);

        if (flag_clr_i && eng_q.irq) begin
            eng_d.irq     = 1'b0;
            eng_d.stretch = 1'b0;
            if (eng_q.phase == PH_TX) begin
                eng_d.tx_sh  = tx_byte_i;
                eng_d.tx_act = 1'b1;
                eng_d.last   = ~ack_en_i;
            end
        end

        if (start_i || stop_i) begin
            if (addressed) begin
                eng_d.status = ST_STOP;
                eng_d.irq    = 1'b1;
            end
            eng_d.phase   = start_i ? PH_ADDR : PH_IDLE;
            eng_d.cnt     = '0;
            eng_d.ack     = 1'b0;
            eng_d.tx_act  = 1'b0;
            eng_d.stretch = 1'b0;
        end else if (eng_q.phase != PH_IDLE) begin
            if (rise_i) begin
                if (eng_q.cnt < CNT_DATA) begin
                    eng_d.sh = {eng_q.sh[BYTE_W-2:0], sda_lvl_i};
                end else begin
                    eng_d.mack = ~sda_lvl_i;
                end
                eng_d.cnt = eng_q.cnt + 1'b1;
            end else if (fall_i) begin
                if (eng_q.tx_act && (eng_q.cnt != '0) && (eng_q.cnt < CNT_DATA)) begin
                    eng_d.tx_sh = {eng_q.tx_sh[BYTE_W-2:0], 1'b1};
                end
                if (eng_q.cnt == CNT_DATA) begin
                    eng_d.tx_act = 1'b0;
                    unique case (eng_q.phase)
                        PH_ADDR: begin
                            eng_d.ack = ack_en_i && (own_hit || gc_hit);
                            if (own_hit)     eng_d.tgt = rd_bit ? PH_TX : PH_RX;
                            else if (gc_hit) eng_d.tgt = PH_GC;
                            else             eng_d.tgt = PH_SKIP;
                        end
                        PH_RX, PH_GC: eng_d.ack = ack_en_i;
                        default:      eng_d.ack = 1'b0;
                    endcase
                end
                if (eng_q.cnt == CNT_END) begin
                    eng_d.cnt = '0;
                    eng_d.ack = 1'b0;
                    unique case (eng_q.phase)
                        PH_ADDR: begin
                            if (eng_q.ack) begin
                                eng_d.phase = eng_q.tgt;
                                ev = 1'b1;
                                if (eng_q.tgt == PH_TX)      ev_code = ST_OWN_R;
                                else if (eng_q.tgt == PH_GC) ev_code = ST_GC;
                                else                         ev_code = ST_OWN_W;
                            end else begin
                                eng_d.phase = PH_SKIP;
                            end
                        end
                        PH_RX: begin
                            ev = 1'b1;
                            ev_code = eng_q.ack ? ST_RX_ACK : ST_RX_NACK;
                            if (!eng_q.ack) eng_d.phase = PH_SKIP;
                        end
                        PH_GC: begin
                            ev = 1'b1;
                            ev_code = eng_q.ack ? ST_GC_ACK : ST_GC_NACK;
                            if (!eng_q.ack) eng_d.phase = PH_SKIP;
                        end
                        PH_TX: begin
                            ev = 1'b1;
                            if (!eng_q.mack) begin
                                ev_code = ST_TX_NACK;
                                eng_d.phase = PH_SKIP;
                            end else if (eng_q.last) begin
                                ev_code = ST_TX_LAST;
                                eng_d.phase = PH_SKIP;
                            end else begin
                                ev_code = ST_TX_ACK;
                            end
                        end
                        default: ;
                    endcase
                    if (ev) begin
                        eng_d.status  = ev_code;
                        eng_d.irq     = 1'b1;
                        eng_d.stretch = 1'b1;
                    end
                end
            end
        end

        if (!enable_i) begin
            eng_d = ENG_RST;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q <= ENG_RST;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe_o  = eng_q.ack | (eng_q.tx_act & ~eng_q.tx_sh[BYTE_W-1]);
    assign scl_oe_o  = eng_q.stretch;
    assign flag_o    = eng_q.irq;
    assign status_o  = eng_q.status;
    assign rx_byte_o = eng_q.sh;

    AST_SINGLE_SDA_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(eng_q.ack && eng_q.tx_act)); // R6

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni || !enable_i)
        (scl_lvl_i && $past(scl_lvl_i)) |-> $stable(sda_oe_o)); // R6
endmodule

// File: rtl/i2cs_gated_slave.sv
module i2cs_gated_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              ack_en_i,
    input  logic              gcall_en_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              flag_clr_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              flag_o,
    output logic [7:0]        status_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic core_sda_oe, core_scl_oe;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_lvl),
        .sda_o      (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2cs_engine i_engine (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .ack_en_i   (ack_en_i),
        .gcall_en_i (gcall_en_i),
        .own_addr_i (own_addr_i),
        .flag_clr_i (flag_clr_i),
        .tx_byte_i  (tx_byte_i),
        .scl_lvl_i  (scl_lvl),
        .sda_lvl_i  (sda_lvl),
        .rise_i     (scl_rise),
        .fall_i     (scl_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .sda_oe_o   (core_sda_oe),
        .scl_oe_o   (core_scl_oe),
        .flag_o     (flag_o),
        .status_o   (status_o),
        .rx_byte_o  (rx_byte_o)
    );

    assign sda_oe_o = core_sda_oe;
    assign scl_oe_o = core_scl_oe;

    AST_OFF_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!sda_oe_o && !scl_oe_o && !flag_o)); // R1

    AST_STRETCH_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_oe_o |-> flag_o); // R3

    AST_FLAG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !flag_clr_i && enable_i) |=> flag_o); // R3

    AST_STATUS_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && $past(enable_i) && (status_o != $past(status_o))) |-> flag_o); // R2
endmodule

// File: tb/test_i2cs_gated_slave.sv
module test_i2cs_gated_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1, ack_en = 1'b1, gcall_en = 1'b0, flag_clr = 1'b0;
    logic [6:0] own_addr = 7'h2A;
    logic [7:0] tx_byte = 8'h00;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, flag;
    logic [7:0] status, rx_byte;
    wire scl_line = scl_m & ~scl_oe;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2cs_gated_slave i_i2cs_gated_slave (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .ack_en_i(ack_en),
        .gcall_en_i(gcall_en), .own_addr_i(own_addr), .flag_clr_i(flag_clr),
        .tx_byte_i(tx_byte), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .flag_o(flag),
        .status_o(status), .rx_byte_o(rx_byte)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_high();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(Q);
        scl_high(); wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(Q);
        scl_high(); wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic m_bit(input logic b, output logic seen);
        sda_m = b; wq(Q);
        scl_high(); wq(Q);
        seen = sda_line;
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_write(input logic [7:0] b, input int raise_at, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            if (7 - i == raise_at) ack_en = 1'b1;
            m_bit(b[i], s);
        end
        m_bit(1'b1, s);
        acked = ~s;
        sda_m = 1'b1;
    endtask

    task automatic m_read(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            v[i] = s;
        end
        m_bit(~give_ack, s);
        sda_m = 1'b1;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; @(negedge clk);
        flag_clr = 1'b0; wq(2);
    endtask

    task automatic t_reset();
        chk(status == 8'hF8, "R1 reset status", status, 8'hF8);
        chk(!flag && !scl_oe && !sda_oe, "R1 reset outputs", {flag, scl_oe, sda_oe}, 0);
    endtask

    task automatic t_disabled();
        logic a;
        enable = 1'b0; wq(2);
        m_start(); m_write(8'h54, -1, a);
        chk(!a, "R1 no ack when disabled", a, 0);
        chk(status == 8'hF8 && !flag, "R1 disabled status", status, 8'hF8);
        m_stop(); enable = 1'b1; wq(2);
    endtask

    task automatic t_mismatch();
        logic a;
        m_start(); m_write(8'h30, -1, a);
        chk(!a && !flag, "R13 foreign address ignored", {a, flag}, 0);
        chk(status == 8'hF8, "R13 status kept", status, 8'hF8);
        m_stop();
    endtask

    task automatic t_receive();
        logic a;
        m_start(); m_write(8'h54, -1, a);
        chk(a, "R2 own write acked", a, 1);
        chk(status == 8'h60 && flag, "R2 status 0x60", status, 8'h60);
        chk(scl_oe, "R3 SCL held low", scl_oe, 1);
        clear_flag();
        chk(!flag && !scl_oe, "R3 clear releases", {flag, scl_oe}, 0);
        m_write(8'hA5, -1, a);
        chk(a && status == 8'h80, "R4 data acked 0x80", status, 8'h80);
        chk(rx_byte == 8'hA5, "R4 received byte", rx_byte, 8'hA5);
        clear_flag();
        ack_en = 1'b0;
        m_write(8'h3C, -1, a);
        chk(!a && status == 8'h88, "R4 data nacked 0x88", status, 8'h88);
        clear_flag(); ack_en = 1'b1;
        m_write(8'h11, -1, a);
        chk(!a && !flag, "R4 not addressed after 0x88", {a, flag}, 0);
        m_stop();
        chk(status == 8'h88 && !flag, "R4 no stop code when not addressed", status, 8'h88);
    endtask

    task automatic t_stop_restart();
        logic a;
        logic [7:0] v;
        m_start(); m_write(8'h54, -1, a); clear_flag();
        m_write(8'h42, -1, a); clear_flag();
        m_stop();
        chk(status == 8'hA0 && flag && !scl_oe, "R12 stop while addressed", status, 8'hA0);
        clear_flag();
        m_start(); m_write(8'h54, -1, a); clear_flag();
        m_start();
        chk(status == 8'hA0 && flag && !scl_oe, "R12 repeated start while addressed", status, 8'hA0);
        clear_flag();
        m_write(8'h55, -1, a);
        chk(a && status == 8'hA8, "R6 own read acked 0xA8", status, 8'hA8);
        tx_byte = 8'h0F; clear_flag();
        m_read(1'b0, v);
        chk(v == 8'h0F, "R6 transmitted byte", v, 8'h0F);
        chk(status == 8'hC0, "R7 master nack 0xC0", status, 8'hC0);
        clear_flag(); m_stop();
    endtask

    task automatic t_general_call();
        logic a;
        gcall_en = 1'b1;
        m_start(); m_write(8'h00, -1, a);
        chk(a && status == 8'h70, "R5 general call acked 0x70", status, 8'h70);
        clear_flag();
        m_write(8'h77, -1, a);
        chk(a && status == 8'h90, "R5 general call data 0x90", status, 8'h90);
        clear_flag(); ack_en = 1'b0;
        m_write(8'h66, -1, a);
        chk(!a && status == 8'h98, "R5 general call data nack 0x98", status, 8'h98);
        clear_flag(); ack_en = 1'b1; m_stop();
        gcall_en = 1'b0;
        m_start(); m_write(8'h00, -1, a);
        chk(!a && !flag, "R5 general call disabled", {a, flag}, 0);
        m_stop();
    endtask

    task automatic t_transmit();
        logic a;
        logic [7:0] v;
        m_start(); m_write(8'h55, -1, a);
        chk(a && status == 8'hA8, "R6 enter transmit", status, 8'hA8);
        tx_byte = 8'hC3; ack_en = 1'b1; clear_flag();
        m_read(1'b1, v);
        chk(v == 8'hC3, "R6 first byte MSB first", v, 8'hC3);
        chk(status == 8'hB8 && flag, "R7 master ack 0xB8", status, 8'hB8);
        tx_byte = 8'h5E; clear_flag();
        m_read(1'b0, v);
        chk(v == 8'h5E && status == 8'hC0, "R7 second byte then 0xC0", status, 8'hC0);
        clear_flag(); m_stop();
        m_start(); m_write(8'h55, -1, a);
        tx_byte = 8'h99; ack_en = 1'b0; clear_flag();
        m_read(1'b1, v);
        chk(v == 8'h99 && status == 8'hC8, "R8 last byte 0xC8", status, 8'hC8);
        chk(!sda_oe, "R8 SDA released", sda_oe, 0);
        ack_en = 1'b1; clear_flag();
        m_read(1'b0, v);
        chk(v == 8'hFF && !flag, "R8 not addressed after 0xC8", v, 8'hFF);
        m_stop();
    endtask

    task automatic t_detached();
        logic a;
        logic [7:0] pre;
        gcall_en = 1'b1; ack_en = 1'b0;
        pre = status;
        m_start(); m_write(8'h54, -1, a);
        chk(!a && !flag && status == pre, "R9 own address ignored detached", status, pre);
        m_write(8'h5A, -1, a);
        chk(rx_byte == 8'h5A, "R10 data still shifted", rx_byte, 8'h5A);
        m_start(); m_write(8'h00, -1, a);
        chk(!a && !flag, "R9 general call ignored detached", {a, flag}, 0);
        m_stop();
        gcall_en = 1'b0; ack_en = 1'b1;
        m_start(); m_write(8'h54, -1, a);
        chk(a && status == 8'h60, "R10 recognition resumes after START", status, 8'h60);
        clear_flag(); m_stop(); clear_flag();
    endtask

    task automatic t_partial();
        logic a;
        ack_en = 1'b0;
        m_start(); m_write(8'h54, 4, a);
        chk(a && status == 8'h60 && flag, "R11 late enable still recognized", status, 8'h60);
        clear_flag(); m_stop(); clear_flag();
    endtask

    initial begin
        wq(5); rst_n = 1'b1; wq(5);
        t_reset();
        t_disabled();
        t_mismatch();
        t_receive();
        t_stop_restart();
        t_general_call();
        t_transmit();
        t_detached();
        t_partial();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule